// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block manages a shared endpoint FIFO memory that is split into equal units of `UNIT_BYTES` bytes. It keeps one bit per unit: set means used, clear means free. An allocation request carries an endpoint's maximum packet size in bytes and a slot number. The block turns the packet size into a power-of-two segment and multiplies that segment by the slot number plus one to get the region size. It then runs a first-fit search, starting at unit 0, for a run of free units long enough to hold the region. On success it returns the region's start unit, its length, its byte address, the same address shifted right by four for an endpoint configuration field, the log2 of the segment size, and the total region size in bytes.

A release request names a start unit and a length, and clears exactly those bits. Both request kinds enter through one valid/ready port. Each request gets one response on a valid/ready port. The search checks one candidate start unit per clock. `busy` is high while the search runs.

Top module: `segAllocTop`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid`, `busy` and `freeErr` are 0, and every unit is free, so the first allocation starts at unit 0.
- R2: The unit count is the packet size divided by `UNIT_BYTES`, rounded up. A packet size of 0 counts as one unit. This count is rounded up to the next power of two. `rspSegLog2` is the log2 of that rounded count times `UNIT_BYTES`.
- R3: If the rounded unit count exceeds `NUM_UNITS`, the status is INVALID (code 1). The bitmap does not change, and the start, length, size, address and field outputs are 0.
- R4: The region length in units is the rounded unit count times (slot + 1). `rspSizeBytes` is that length times `UNIT_BYTES`.
- R5: The region starts at the lowest unit index from which the whole length is free. On success, those units become used.
- R6: If no free run of the region length exists, the status is OVERFLOW (code 2). The bitmap does not change, and the data outputs are 0.
- R7: On success, the status is OK (code 0). `rspAddr` is `BASE_ADDR` plus the start unit times `UNIT_BYTES`, and `rspAddrField` is `rspAddr` shifted right by 4.
- R8: A release request (`reqIsFree`=1) clears the units from `reqStartUnit` up to `reqStartUnit`+`reqLenUnits`-1 and no others. Its response has status OK and zero data outputs.
- R9: Releasing a range that contains an already free unit sets `freeErr`. `freeErr` stays set until reset.
- R10: `reqReady` is high only while the block is idle. `busy` is high during the search and low while a response waits. A response and its fields stay stable until `rspReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and accepting a request |
| reqIsFree | input | 1 | 1 = release, 0 = allocate |
| reqMaxp | input | MAXP_W | Maximum packet size in bytes (allocate) |
| reqSlot | input | SLOT_W | Slot number (allocate) |
| reqStartUnit | input | IDX_W | First unit to release |
| reqLenUnits | input | LEN_W | Number of units to release |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspStatus | output | 2 | 0 OK, 1 INVALID, 2 OVERFLOW |
| rspStartUnit | output | IDX_W | Start unit of the granted region |
| rspLenUnits | output | LEN_W | Region length in units |
| rspSegLog2 | output | LG_W | log2 of segment size in bytes |
| rspSizeBytes | output | SZ_W | Region size in bytes |
| rspAddr | output | ADDR_W | Region byte address |
| rspAddrField | output | ADDR_W-4 | Byte address shifted right by 4 |
| busy | output | 1 | Search in progress |
| freeErr | output | 1 | Sticky error: a released unit was already free |

## Verification
Allocations use packet sizes that are exact multiples of the unit, sizes that need rounding up, a packet size of zero, and a size that overflows the memory's power-of-two range. Each size is paired with slot numbers that multiply the region. This separates the rounding step from the slot-multiplication step. Releases punch a hole in the middle of the used area, and a later smaller request must land in that hole rather than after the used area, which shows that the search is first-fit from unit 0. A request that matches the whole memory is tried while the memory is full, which must fail, and again after a full release, which must succeed at unit 0. A response held back for several cycles shows that its fields stay stable.

// File: rtl/segAllocPkg.sv
package segAllocPkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_INVALID  = 2'd1,
    ST_OVERFLOW = 2'd2
  } allocStatusE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAlloc;
    logic stepIdx;
    logic commit;
    logic applyFree;
  } dpStrobeT;
endpackage

// File: rtl/segCalc.sv
// Size arithmetic: units from bytes, power-of-two rounding, slot scaling.
module segCalc #(
  parameter int MAXP_W    = 16,
  parameter int SLOT_W    = 2,
  parameter int UNIT_LG   = 6,
  parameter int NUM_UNITS = 32,
  parameter int LEN_W     = 8,
  parameter int LG_W      = 5
) (
  input  logic [MAXP_W-1:0] maxp,
  input  logic [SLOT_W-1:0] slot,
  output logic              tooBig,
  output logic [LEN_W-1:0]  lenUnits,
  output logic [LG_W-1:0]   segLog2
);
  localparam int CW   = MAXP_W + 2;
  localparam int KW   = $clog2(MAXP_W + 2);
  localparam int KMAX = $clog2(NUM_UNITS + 1) - 1;

  logic [CW-1:0]   unitsRaw, unitsAdj;
  logic [KW-1:0]   kSel;
  logic [SLOT_W:0] slotPlus;

  always_comb begin
    unitsRaw = (CW'(maxp) + CW'((1 << UNIT_LG) - 1)) >> UNIT_LG;
    unitsAdj = (unitsRaw == '0) ? CW'(1) : unitsRaw;
    kSel = KW'(MAXP_W);
    for (int k = MAXP_W; k >= 0; k--) begin
      if ((CW'(1) << k) >= unitsAdj) kSel = KW'(k);
    end
    tooBig   = int'(kSel) > KMAX;
    slotPlus = {1'b0, slot} + 1'b1;
    lenUnits = tooBig ? '0 : (LEN_W'(slotPlus) << kSel);
    segLog2  = LG_W'(kSel) + LG_W'(UNIT_LG);
  end
endmodule

// File: rtl/allocDatapath.sv
// Unit bitmap, candidate index and window checks.
module allocDatapath
  import segAllocPkg::*;
#(
  parameter int NUM_UNITS = 32,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 8,
  parameter int LG_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strb,
  input  logic [LEN_W-1:0] lenIn,
  input  logic [LG_W-1:0]  segLog2In,
  input  logic [IDX_W-1:0] freeStart,
  input  logic [LEN_W-1:0] freeLen,
  output logic             fitNow,
  output logic             pastEnd,
  output logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] lenQ,
  output logic [LG_W-1:0]  segLog2Q,
  output logic             freeErr
);
  localparam int SUM_W = LEN_W + 1;

  logic [NUM_UNITS-1:0] usedMap, winMask, freeMask;
  logic [SUM_W-1:0]     winEnd, freeEnd;

  assign winEnd  = SUM_W'(idx) + SUM_W'(lenQ);
  assign freeEnd = SUM_W'(freeStart) + SUM_W'(freeLen);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign winMask[u]  = (SUM_W'(u) >= SUM_W'(idx)) && (SUM_W'(u) < winEnd);
    assign freeMask[u] = (SUM_W'(u) >= SUM_W'(freeStart)) && (SUM_W'(u) < freeEnd);
  end

  assign pastEnd = winEnd > SUM_W'(NUM_UNITS);
  assign fitNow  = !pastEnd && ((usedMap & winMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMap  <= '0;
      idx      <= '0;
      lenQ     <= '0;
      segLog2Q <= '0;
      freeErr  <= 1'b0;
    end else begin
      if (strb.loadAlloc) begin
        idx      <= '0;
        lenQ     <= lenIn;
        segLog2Q <= segLog2In;
      end else if (strb.stepIdx) begin
        idx <= idx + 1'b1;
      end
      if (strb.commit)    usedMap <= usedMap | winMask;
      if (strb.applyFree) begin
        usedMap <= usedMap & ~freeMask;
        if ((freeMask & ~usedMap) != '0) freeErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/allocCtrl.sv
// Request/search/response sequencing.
module allocCtrl
  import segAllocPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsFree,
  input  logic        tooBig,
  input  logic        fitNow,
  input  logic        pastEnd,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        busy,
  output logic        rspValid,
  output allocStatusE status,
  output logic        fieldsOn,
  output dpStrobeT    strb
);
  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_RESP} stateE;
  stateE state;

  assign reqReady = (state == S_IDLE);
  assign busy     = (state == S_SEARCH);
  assign rspValid = (state == S_RESP);

  always_comb begin
    strb = '0;
    if (state == S_IDLE && reqValid) begin
      strb.applyFree = reqIsFree;
      strb.loadAlloc = !reqIsFree && !tooBig;
    end
    if (state == S_SEARCH) begin
      strb.commit  = !pastEnd && fitNow;
      strb.stepIdx = !pastEnd && !fitNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      status   <= ST_OK;
      fieldsOn <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          fieldsOn <= 1'b0;
          if (reqIsFree) begin
            status <= ST_OK;
            state  <= S_RESP;
          end else if (tooBig) begin
            status <= ST_INVALID;
            state  <= S_RESP;
          end else begin
            state <= S_SEARCH;
          end
        end
        S_SEARCH: if (pastEnd) begin
          status <= ST_OVERFLOW;
          state  <= S_RESP;
        end else if (fitNow) begin
          status   <= ST_OK;
          fieldsOn <= 1'b1;
          state    <= S_RESP;
        end
        default: if (rspReady) state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/segAllocTop.sv
module segAllocTop
  import segAllocPkg::*;
#(
  parameter int          NUM_UNITS  = 32,
  parameter int          UNIT_BYTES = 64,
  parameter int          MAXP_W     = 16,
  parameter int          SLOT_W     = 2,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'h0400,
  localparam int UNIT_LG = $clog2(UNIT_BYTES),
  localparam int IDX_W   = $clog2(NUM_UNITS + 1),
  localparam int LEN_W   = IDX_W + SLOT_W,
  localparam int LG_W    = $clog2(MAXP_W + UNIT_LG + 2),
  localparam int SZ_W    = LEN_W + UNIT_LG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsFree,
  input  logic [MAXP_W-1:0] reqMaxp,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [IDX_W-1:0]  reqStartUnit,
  input  logic [LEN_W-1:0]  reqLenUnits,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [1:0]        rspStatus,
  output logic [IDX_W-1:0]  rspStartUnit,
  output logic [LEN_W-1:0]  rspLenUnits,
  output logic [LG_W-1:0]   rspSegLog2,
  output logic [SZ_W-1:0]   rspSizeBytes,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-5:0] rspAddrField,
  output logic              busy,
  output logic              freeErr
);
  dpStrobeT         strb;
  allocStatusE      status;
  logic             tooBig, fitNow, pastEnd, fieldsOn, showFields;
  logic [LEN_W-1:0] lenCalc, lenQ;
  logic [LG_W-1:0]  segCalcLg, segLog2Q;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] byteAddr;

  segCalc #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_LG(UNIT_LG),
            .NUM_UNITS(NUM_UNITS), .LEN_W(LEN_W), .LG_W(LG_W)) i_calc (
    .maxp(reqMaxp), .slot(reqSlot), .tooBig(tooBig),
    .lenUnits(lenCalc), .segLog2(segCalcLg));

  allocDatapath #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W), .LEN_W(LEN_W),
                  .LG_W(LG_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lenIn(lenCalc),
    .segLog2In(segCalcLg), .freeStart(reqStartUnit), .freeLen(reqLenUnits),
    .fitNow(fitNow), .pastEnd(pastEnd), .idx(idx), .lenQ(lenQ),
    .segLog2Q(segLog2Q), .freeErr(freeErr));

  allocCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFree(reqIsFree),
    .tooBig(tooBig), .fitNow(fitNow), .pastEnd(pastEnd), .rspReady(rspReady),
    .reqReady(reqReady), .busy(busy), .rspValid(rspValid), .status(status),
    .fieldsOn(fieldsOn), .strb(strb));

  assign showFields   = rspValid && fieldsOn;
  assign byteAddr     = ADDR_W'(BASE_ADDR) + (ADDR_W'(idx) << UNIT_LG);
  assign rspStatus    = status;
  assign rspStartUnit = showFields ? idx : '0;
  assign rspLenUnits  = showFields ? lenQ : '0;
  assign rspSegLog2   = showFields ? segLog2Q : '0;
  assign rspSizeBytes = showFields ? (SZ_W'(lenQ) << UNIT_LG) : '0;
  assign rspAddr      = showFields ? byteAddr : '0;
  assign rspAddrField = showFields ? byteAddr[ADDR_W-1:4] : '0;
endmodule

// File: rtl/segAllocChecker.sv
module segAllocChecker #(
  parameter int NUM_UNITS = 32,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 8,
  parameter int ADDR_W    = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [1:0]        rspStatus,
  input logic [IDX_W-1:0]  rspStartUnit,
  input logic [LEN_W-1:0]  rspLenUnits,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              busy,
  input logic              freeErr
);
  // R10: ready only while idle
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busy && !rspValid));
  // R10: pending response holds
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspStatus) &&
      $stable(rspStartUnit) && $stable(rspLenUnits) && $stable(rspAddr)));
  // R9: error flag sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    freeErr |=> freeErr);
  // R5: granted region inside memory
  p_ok_inside_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd0 && rspLenUnits != '0) |->
      ((LEN_W + 1)'(rspStartUnit) + (LEN_W + 1)'(rspLenUnits) <= (LEN_W + 1)'(NUM_UNITS)));
  // R3: failed request reports no region
  p_err_no_fields_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus != 2'd0) |-> (rspLenUnits == '0 && rspAddr == '0));
  // R6: overflow only after a search
  p_ovf_after_search_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rspValid) && rspStatus == 2'd2) |-> $past(busy));
endmodule

bind segAllocTop segAllocChecker #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W),
  .LEN_W(LEN_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspStatus(rspStatus), .rspStartUnit(rspStartUnit),
  .rspLenUnits(rspLenUnits), .rspAddr(rspAddr), .busy(busy), .freeErr(freeErr));

// File: tb/test_segAllocTop.sv
module test_segAllocTop;
  localparam int N = 32;
  localparam int UB = 64;
  localparam int BASE = 16'h0400;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqIsFree = 0, rspReady = 0;
  logic [15:0] reqMaxp = 0;
  logic [1:0]  reqSlot = 0;
  logic [5:0]  reqStartUnit = 0;
  logic [7:0]  reqLenUnits = 0;
  logic reqReady, rspValid, busy, freeErr;
  logic [1:0]  rspStatus;
  logic [5:0]  rspStartUnit;
  logic [7:0]  rspLenUnits;
  logic [4:0]  rspSegLog2;
  logic [13:0] rspSizeBytes;
  logic [15:0] rspAddr;
  logic [11:0] rspAddrField;

  int checks = 0, fails = 0;
  bit modelMap [N];
  bit modelErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  segAllocTop i_segAllocTop (.*);

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRsp();
    int guard = 0;
    while (!rspValid && guard < 200) begin @(negedge clk); guard++; end
    checkEq("R10 response arrives", int'(rspValid), 1);
  endtask

  task automatic doAlloc(input int maxp, input int slot, input int hold);
    int units, r, lg, len, start, expSt;
    units = (maxp + UB - 1) / UB;
    if (units == 0) units = 1;
    r = 1; lg = 0;
    while (r < units) begin r *= 2; lg++; end
    len = r * (slot + 1);
    start = -1;
    if (r > N) expSt = 1;
    else begin
      for (int s = 0; s + len <= N && start < 0; s++) begin
        bit ok = 1;
        for (int u = s; u < s + len; u++) if (modelMap[u]) ok = 0;
        if (ok) start = s;
      end
      expSt = (start < 0) ? 2 : 0;
    end
    @(negedge clk);
    reqValid = 1; reqIsFree = 0; reqMaxp = 16'(maxp); reqSlot = 2'(slot);
    @(negedge clk);
    reqValid = 0;
    if (expSt != 1) begin
      checkEq("R10 busy during search", int'(busy), 1);
      checkEq("R10 not ready during search", int'(reqReady), 0);
    end
    waitRsp();
    checkEq("R10 busy low at response", int'(busy), 0);
    checkEq("R3/R6/R7 status", int'(rspStatus), expSt);
    if (expSt == 0) begin
      checkEq("R5 start unit", int'(rspStartUnit), start);
      checkEq("R4 length units", int'(rspLenUnits), len);
      checkEq("R2 seg log2", int'(rspSegLog2), lg + 6);
      checkEq("R4 size bytes", int'(rspSizeBytes), len * UB);
      checkEq("R7 address", int'(rspAddr), BASE + start * UB);
      checkEq("R7 address field", int'(rspAddrField), (BASE + start * UB) >> 4);
      for (int u = start; u < start + len; u++) modelMap[u] = 1;
    end else begin
      checkEq("R3 R6 zero length on error", int'(rspLenUnits), 0);
      checkEq("R3 R6 zero address on error", int'(rspAddr), 0);
    end
    for (int h = 0; h < hold; h++) begin
      logic [15:0] a; logic [1:0] st;
      a = rspAddr; st = rspStatus;
      @(negedge clk);
      checkEq("R10 held valid", int'(rspValid), 1);
      checkEq("R10 held address", int'(rspAddr), int'(a));
      checkEq("R10 held status", int'(rspStatus), int'(st));
    end
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
  endtask

  task automatic doFree(input int start, input int len);
    @(negedge clk);
    reqValid = 1; reqIsFree = 1; reqStartUnit = 6'(start); reqLenUnits = 8'(len);
    @(negedge clk);
    reqValid = 0; reqIsFree = 0;
    for (int u = start; u < start + len && u < N; u++) begin
      if (!modelMap[u]) modelErr = 1;
      modelMap[u] = 0;
    end
    waitRsp();
    checkEq("R8 free status", int'(rspStatus), 0);
    checkEq("R8 free zero length", int'(rspLenUnits), 0);
    checkEq("R9 sticky freeErr", int'(freeErr), int'(modelErr));
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < N; u++) modelMap[u] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkEq("R1 ready after reset", int'(reqReady), 1);
    checkEq("R1 no response after reset", int'(rspValid), 0);
    checkEq("R1 not busy after reset", int'(busy), 0);
    checkEq("R1 freeErr clear", int'(freeErr), 0);
    doAlloc(64, 0, 0);     // R1 R2 exact unit, start 0
    doAlloc(100, 0, 0);    // R2 rounding 2 units
    doAlloc(200, 1, 0);    // R4 4 units x 2 slots
    doAlloc(0, 0, 0);      // R2 zero bytes -> 1 unit
    doAlloc(3000, 0, 0);   // R3 47 -> 64 units, invalid
    doAlloc(1024, 1, 0);   // R6 32 units does not fit
    doAlloc(64, 0, 3);     // R6 map unchanged, R10 hold
    doFree(1, 2);          // R8 hole
    doAlloc(128, 0, 0);    // R5 first fit lands in hole
    checkEq("R5 hole reuse start", modelMap[1] ? 1 : 0, 1);
    doFree(20, 1);         // R9 unit already free
    doFree(0, 32);         // R8 release all
    doAlloc(2048, 0, 0);   // R5 full memory at unit 0
    doAlloc(64, 0, 0);     // R6 memory full
    checkEq("R9 freeErr remains", int'(freeErr), 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule